// File: doc/BRIEF.md
# Sized Logic Unit with Equality Reduction

This block is the bitwise logic unit of a 64-bit integer datapath. Each request carries two source operands, a 3-bit operation code and a 2-bit operand-size field. Plain operations (AND, OR, XOR, XNOR) act only on the low 8, 16, 32 or 64 bits of the operands. Every result bit above the chosen size is zero, so a following branch on zero or non-zero can read the result directly without a separate zero-extend.

Two reduction operations finish equality tests inside the unit. The bitwise XNOR can be folded with AND, which gives "all selected bits equal". The bitwise XOR can be folded with OR, which gives "some selected bit differs". The outcome is spread over all 64 result bits, so the unit returns -1 or 0. Plain operations return after one cycle and reductions after two. The unit accepts one request per clock. The reduction is split into per-byte partial results in the first stage and a final fold in the second stage.

Top module: `logic_reduce_unit`

## Requirements
- R1: Operation codes 000, 001, 010 and 011 give the bitwise AND, OR, XOR and XNOR of `src_a` and `src_b` over the selected width.
- R2: The size field selects the width: 00 is 8 bits, 01 is 16, 10 is 32 and 11 is 64. Every bit of a plain result above that width is zero, XNOR results included.
- R3: Code 111 returns all-ones (64'hFFFF_FFFF_FFFF_FFFF) when the low selected-width bits of the two operands are equal, and 0 otherwise. Operand bits above the width have no effect.
- R4: Code 110 returns all-ones when the operands differ in at least one bit inside the selected width, and 0 otherwise. Differences above the width have no effect.
- R5: Codes 100 and 101 return a zero result with the plain-operation latency.
- R6: For a plain or zero-result code, `rsp_valid` is high in the cycle right after the clock edge that accepts the request.
- R7: For codes 110 and 111, `rsp_valid` is high two cycles after the accepting edge.
- R8: A new request can be accepted on every clock. Results come out in request order, each at its own latency.
- R9: A plain request accepted one cycle after a reduction request finishes in the same cycle as that reduction. In that cycle the reduction result is delivered and the plain result is discarded.
- R10: While `rsp_valid` is low, `rsp_data` is zero.
- R11: A synchronous active-high `rst` clears all in-flight work. `rsp_valid` and `rsp_data` read zero during reset and after it, until a new request completes.
- R12: When `req_valid` is low the other request inputs are ignored, and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_size | input | 2 | Operand-size code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| rsp_valid | output | 1 | Result strobe |
| rsp_data | output | 64 | Result |

## Verification
The bench targets XNOR at narrow sizes. A unit that forgot the zero-extend would return ones above the width there, and the bench also checks for operands equal in the low bits but different above them, where a reduction that leaked past the width would report a false inequality. It checks unequal operands that differ only in the top bit of the chosen width, which catches an off-by-one width mask. It also covers back-to-back mixed traffic and the reduction-then-plain pairing, where wrong latency bookkeeping would either duplicate a strobe or corrupt the delivered value. Finally, it resets the unit while a reduction is in flight, where a stale result would leak out after reset.

// File: rtl/lru_pkg.sv
package lru_pkg;

  localparam int unsigned OP_W = 3;
  localparam int unsigned SZ_W = 2;

  typedef enum logic [OP_W-1:0] {
    LOP_AND      = 3'b000,
    LOP_OR       = 3'b001,
    LOP_XOR      = 3'b010,
    LOP_XNOR     = 3'b011,
    LOP_NONE_A   = 3'b100,
    LOP_NONE_B   = 3'b101,
    LOP_ANY_DIFF = 3'b110,
    LOP_ALL_SAME = 3'b111
  } lop_e;

  // Reduction codes sit in the top quarter of the code space.
  function automatic logic op_is_reduce(input logic [OP_W-1:0] op);
    return op[2] & op[1];
  endfunction

  // Codes 100/101 produce nothing but a zero result.
  function automatic logic op_is_null(input logic [OP_W-1:0] op);
    return op[2] & ~op[1];
  endfunction

  // For reductions, bit 0 selects the AND fold (1) versus the OR fold (0).
  function automatic logic op_fold_all(input logic [OP_W-1:0] op);
    return op[0];
  endfunction

endpackage

// File: rtl/lru_lane_reduce.sv
module lru_lane_reduce #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_bits,
  input  logic              fold_all,
  output logic              lane_flag
);

  always_comb begin
    if (fold_all) lane_flag = &lane_bits;
    else          lane_flag = |lane_bits;
  end

endmodule

// File: rtl/lru_front_stage.sv
module lru_front_stage
  import lru_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [SZ_W-1:0]   in_size,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              s1_plain_valid,
  output logic              s1_red_valid,
  output logic              s1_fold_all,
  output logic [DATA_W-1:0] s1_data,
  output logic [SZ_W-1:0]   s1_size,
  output logic [LANES-1:0]  s1_lane_flags
);

  function automatic logic [DATA_W-1:0] width_mask(input logic [SZ_W-1:0] sz);
    int w;
    logic [DATA_W-1:0] m;
    w = LANE_W << sz;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < w);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] bit_op(input logic [1:0] sel,
                                               input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    case (sel)
      2'b00:   return a & b;
      2'b01:   return a | b;
      2'b10:   return a ^ b;
      default: return ~(a ^ b);
    endcase
  endfunction

  logic [DATA_W-1:0] mask_w;
  logic [DATA_W-1:0] raw_w;
  logic [DATA_W-1:0] plain_w;
  logic [DATA_W-1:0] fill_w;
  logic [LANES-1:0]  lane_flag_d;
  logic              take_red;
  logic              take_plain;

  assign mask_w     = width_mask(in_size);
  assign raw_w      = bit_op(in_op[1:0], in_a, in_b);
  assign plain_w    = op_is_null(in_op) ? '0 : (raw_w & mask_w);
  // Bits outside the width are made neutral for the fold:
  // ones for the AND fold, zeros for the OR fold.
  assign fill_w     = op_fold_all(in_op) ? (raw_w | ~mask_w) : (raw_w & mask_w);
  assign take_red   = in_valid & op_is_reduce(in_op);
  assign take_plain = in_valid & ~op_is_reduce(in_op);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lru_lane_reduce #(.LANE_W(LANE_W)) u_lane (
      .lane_bits (fill_w[g*LANE_W +: LANE_W]),
      .fold_all  (op_fold_all(in_op)),
      .lane_flag (lane_flag_d[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_plain_valid <= 1'b0;
      s1_red_valid   <= 1'b0;
      s1_fold_all    <= 1'b0;
      s1_data        <= '0;
      s1_size        <= '0;
      s1_lane_flags  <= '0;
    end else begin
      s1_plain_valid <= take_plain;
      s1_red_valid   <= take_red;
      s1_fold_all    <= op_fold_all(in_op);
      s1_data        <= take_plain ? plain_w : '0;
      s1_size        <= in_size;
      s1_lane_flags  <= lane_flag_d;
    end
  end

  // R2
  plain_extend_chk: assert property (@(posedge clk) disable iff (rst)
    s1_plain_valid |-> (s1_data & ~width_mask(s1_size)) == '0);

endmodule

// File: rtl/lru_combine_stage.sv
module lru_combine_stage #(
  parameter int DATA_W = 64,
  parameter int LANES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_red_valid,
  input  logic              s1_fold_all,
  input  logic [LANES-1:0]  s1_lane_flags,
  output logic              s2_valid,
  output logic [DATA_W-1:0] s2_data
);

  function automatic logic fold_lanes(input logic [LANES-1:0] f, input logic all_mode);
    return all_mode ? (&f) : (|f);
  endfunction

  logic fold_bit;
  assign fold_bit = fold_lanes(s1_lane_flags, s1_fold_all);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_data  <= '0;
    end else begin
      s2_valid <= s1_red_valid;
      s2_data  <= (s1_red_valid && fold_bit) ? '1 : '0;
    end
  end

  // R3
  broadcast_chk: assert property (@(posedge clk) disable iff (rst)
    s2_valid |-> (s2_data == '0 || s2_data == '1));

endmodule

// File: rtl/logic_reduce_unit.sv
module logic_reduce_unit
  import lru_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic              s1_plain_valid;
  logic              s1_red_valid;
  logic              s1_fold_all;
  logic [DATA_W-1:0] s1_data;
  logic [SZ_W-1:0]   s1_size;
  logic [LANES-1:0]  s1_lane_flags;
  logic              s2_valid;
  logic [DATA_W-1:0] s2_data;

  // Named events for the assertions.
  logic plain_drop;
  logic red_issue;
  logic plain_issue;

  assign red_issue   = req_valid & op_is_reduce(req_op);
  assign plain_issue = req_valid & ~op_is_reduce(req_op);

  lru_front_stage #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_front (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (req_valid),
    .in_op          (req_op),
    .in_size        (req_size),
    .in_a           (src_a),
    .in_b           (src_b),
    .s1_plain_valid (s1_plain_valid),
    .s1_red_valid   (s1_red_valid),
    .s1_fold_all    (s1_fold_all),
    .s1_data        (s1_data),
    .s1_size        (s1_size),
    .s1_lane_flags  (s1_lane_flags)
  );

  lru_combine_stage #(.DATA_W(DATA_W), .LANES(LANES)) u_comb (
    .clk           (clk),
    .rst           (rst),
    .s1_red_valid  (s1_red_valid),
    .s1_fold_all   (s1_fold_all),
    .s1_lane_flags (s1_lane_flags),
    .s2_valid      (s2_valid),
    .s2_data       (s2_data)
  );

  assign plain_drop = s1_plain_valid & s2_valid;
  assign rsp_valid  = s1_plain_valid | s2_valid;

  always_comb begin
    if (s2_valid)            rsp_data = s2_data;
    else if (s1_plain_valid) rsp_data = s1_data;
    else                     rsp_data = '0;
  end

  // R6
  plain_latency_chk: assert property (@(posedge clk) disable iff (rst)
    plain_issue |=> rsp_valid);

  // R7
  reduce_latency_chk: assert property (@(posedge clk) disable iff (rst)
    red_issue |=> ##1 (rsp_valid && (rsp_data == '0 || rsp_data == '1)));

  // R9
  drop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    plain_drop |-> (rsp_data == '0 || rsp_data == '1));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> rsp_data == '0);

  // R11
  post_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);

endmodule

// File: tb/logic_reduce_unit_test.sv
module logic_reduce_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'b000;
  logic [1:0]  req_size = 2'b00;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  int    cyc = 0;
  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  string idle_tag = "R10";

  int          q_due[$];
  logic [63:0] q_data[$];
  string       q_tag[$];

  logic_reduce_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .src_a(src_a), .src_b(src_b),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] sz,
                                        input logic [63:0] a, input logic [63:0] b);
    int w;
    logic [63:0] r;
    bit diff;
    w = 8 * (1 << sz);
    r = '0;
    diff = 0;
    for (int i = 0; i < w; i++) begin
      if (a[i] != b[i]) diff = 1;
      case (op)
        3'd0: r[i] = a[i] & b[i];
        3'd1: r[i] = a[i] | b[i];
        3'd2: r[i] = a[i] ^ b[i];
        3'd3: r[i] = (a[i] == b[i]);
        default: r[i] = 1'b0;
      endcase
    end
    if (op == 3'd6) r = diff ? {64{1'b1}} : 64'd0;
    if (op == 3'd7) r = diff ? 64'd0 : {64{1'b1}};
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: present one request and record its expected result.
  task automatic issue(input logic [2:0] op, input logic [1:0] sz,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    int due;
    @(negedge clk);
    req_valid = 1'b1;
    req_op = op;
    req_size = sz;
    src_a = a;
    src_b = b;
    due = (op == 3'd6 || op == 3'd7) ? cyc + 2 : cyc + 1;
    // R9: a plain result landing on a reduction's cycle is discarded.
    if (q_due.size() > 0 && q_due[$] == due) return;
    q_due.push_back(due);
    q_data.push_back(model(op, sz, a, b));
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compare outputs one step after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (done) break;
      if (rst) begin
        check(!rsp_valid && rsp_data == '0, "R11", rsp_data, 64'd0);
      end else if (q_due.size() > 0 && q_due[0] == cyc) begin
        check(rsp_valid === 1'b1, {q_tag[0], " valid"}, {63'd0, rsp_valid}, 64'd1);
        check(rsp_data === q_data[0], q_tag[0], rsp_data, q_data[0]);
        void'(q_due.pop_front());
        void'(q_data.pop_front());
        void'(q_tag.pop_front());
      end else begin
        check(!rsp_valid && rsp_data == '0, idle_tag, rsp_data, 64'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  localparam logic [63:0] PA = 64'hF0F0_A5A5_1234_80FF;
  localparam logic [63:0] PB = 64'h0FF0_5AA5_F00F_8001;

  initial begin
    // R11: reset state observed by the monitor.
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1 / R2: every plain op at every size.
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++) begin
        issue(3'(o), 2'(s), PA, PB, (o == 3) ? "R2" : "R1");
        idle(1);
      end

    // R2: XNOR of equal bytes must not set bits 63:8.
    issue(3'd3, 2'b00, 64'h1111_2222_3333_4455, 64'h9999_8888_7777_6655, "R2");
    idle(2);

    // R3 / R4: equal low bits, different high bits, every size.
    for (int s = 0; s < 4; s++) begin
      logic [63:0] hi_noise;
      hi_noise = (s == 3) ? 64'd0 : (64'hDEAD_BEEF_CAFE_F00D << (8 << s));
      issue(3'd7, 2'(s), PA, PA ^ hi_noise, "R3");
      idle(2);
      issue(3'd6, 2'(s), PA, PA ^ hi_noise, "R4");
      idle(2);
    end

    // R3 / R4: difference only in the top bit of the width.
    for (int s = 0; s < 4; s++) begin
      logic [63:0] top;
      top = 64'd1 << ((8 << s) - 1);
      issue(3'd7, 2'(s), PB, PB ^ top, "R3");
      idle(2);
      issue(3'd6, 2'(s), PB, PB ^ top, "R4");
      idle(2);
    end

    // R5: zero-result codes.
    issue(3'd4, 2'b11, PA, PB, "R5");
    issue(3'd5, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    idle(2);

    // R6 / R7 / R8: back-to-back stream without bubbles.
    issue(3'd1, 2'b10, PA, PB, "R8");
    issue(3'd2, 2'b01, PA, PB, "R8");
    issue(3'd7, 2'b11, PA, PA, "R7");
    issue(3'd7, 2'b00, PA, PB, "R7");
    idle(1);
    issue(3'd0, 2'b11, PA, PB, "R6");
    issue(3'd6, 2'b10, PA, PB, "R8");
    idle(3);

    // R9: reduction followed at once by a plain request.
    issue(3'd7, 2'b01, PB, PB, "R9");
    issue(3'd3, 2'b11, PA, PB, "R9");
    issue(3'd2, 2'b00, PA, PB, "R9");
    idle(3);

    // R12: junk on the inputs with req_valid low.
    idle_tag = "R12";
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_op = 3'(k + 4);
      req_size = 2'(k);
      src_a = PA ^ 64'(k);
      src_b = PB;
    end
    idle(3);
    idle_tag = "R10";

    // R11: reset while a reduction is in flight.
    issue(3'd7, 2'b11, PA, PA, "R11");
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    q_due.delete();
    q_data.delete();
    q_tag.delete();
    @(negedge clk);
    rst = 1'b0;
    idle(4);

    done = 1;
    @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule